// File: doc/BRIEF.md
# USB Line-State Transceiver Interface with Eye-Pattern Generator

This block sits between a USB serial interface engine and an external full-speed or low-speed transceiver. On the transmit side it takes a requested line symbol (single-ended zero, J or K) from the engine. It drives that symbol onto a two-wire differential output pair and an active-low output enable. On the receive side it passes the transceiver's two single-ended inputs through a synchronizer and decodes them into a bus-state code. An output-enable monitor flag shows whether the block is driving the bus or listening to it.

A board test mode makes the block act as if it had switched from receive to transmit. In that mode it streams an endless alternating J/K symbol sequence, one symbol per bit strobe. The first symbol depends on the speed mode: the sequence starts with K at full speed and with J at low speed. The eye-pattern request overrides any transmit request from the engine. A sticky error flag records illegal transmit requests and receive error codes until a clear input removes it.

The control state machine has four states. LISTEN has the output disabled and idles at J. DRIVE sends the engine's latched symbol. EYE_FIRST and EYE_SECOND are the two phases of the test pattern. On a bit strobe with the module enabled, the following transitions apply:
- From LISTEN or DRIVE, the machine goes to EYE_FIRST when the test enable is set, goes to DRIVE when a transmit request is present, and goes to LISTEN otherwise.
- EYE_FIRST goes to EYE_SECOND, and EYE_SECOND goes to EYE_FIRST, while the test enable stays set. Either eye state goes to LISTEN once the test enable is cleared.
- Dropping the module enable sends every state to LISTEN on the next clock, whether or not a strobe is present.

Top module: `usb_line_if`

## Requirements
- R1: The output pair {tx_dp,tx_dm} never takes the value 2'b11. The only values driven are 2'b00 (single-ended zero), 2'b01 (differential 0) and 2'b10 (differential 1).
- R2: A bit strobe with tx_req high, the block enabled and no test request moves the block into DRIVE and latches tx_sym. The pair then shows the symbol after that clock edge. The tx_sym codes are 00=SE0, 01=J and 10=K. SE0 drives 2'b00. J drives 2'b10 at full speed (fs_mode=1) and 2'b01 at low speed. K drives the opposite differential level.
- R3: oe_n is low only in DRIVE and the eye states, and it is high in LISTEN and in reset. oe_mon is always the inverse of oe_n.
- R4: The inputs {rx_dp,rx_dm} appear on rx_state after two clock edges and not after one. The decoding is 00→0 (SE0), 01→1 (low-speed state), 10→2 (full-speed state) and 11→3 (error).
- R5: A strobe with eye_en and mod_en high moves the block from LISTEN or DRIVE into the test pattern. oe_n goes low and the first symbol is K at full speed or J at low speed. In both modes that symbol is the pair value 2'b01.
- R6: While eye_en stays high, each strobe flips the pair to the other differential level, without end. eye_en takes priority over tx_req.
- R7: With mod_en high, the state and oe_n hold between strobes, and a change of tx_sym has no effect until the next strobe.
- R8: A strobe in an eye state with eye_en low returns the block to LISTEN. oe_n goes high and the pair idles at J.
- R9: While mod_en is low, the block is forced to LISTEN on the next clock. eye_en and tx_req are ignored, and an illegal request does not set the error flag.
- R10: err_flag is set by tx_req with tx_sym=11 while mod_en is high, or by rx_state=3. It stays set until err_clr is high in a cycle with no set condition. When set and clear occur in the same cycle, set wins.
- R11: An illegal request (tx_sym=11) taken on a strobe is sent as J, never as 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Module enable |
| fs_mode | input | 1 | 1 = full speed, 0 = low speed |
| eye_en | input | 1 | Eye-pattern test enable |
| bit_stb | input | 1 | One-cycle bit-time strobe |
| tx_req | input | 1 | Engine requests to transmit |
| tx_sym | input | 2 | Requested symbol: 00 SE0, 01 J, 10 K, 11 illegal |
| rx_dp | input | 1 | Single-ended input from the transceiver, plus line |
| rx_dm | input | 1 | Single-ended input from the transceiver, minus line |
| err_clr | input | 1 | Clears the sticky error flag |
| tx_dp | output | 1 | Differential output pair, high bit |
| tx_dm | output | 1 | Differential output pair, low bit |
| oe_n | output | 1 | Active-low transceiver output enable |
| oe_mon | output | 1 | High while the block drives the bus |
| rx_state | output | 2 | Decoded bus state |
| err_flag | output | 1 | Sticky error flag |

## Verification
Two functions can land on one clock edge, and each pairing is provoked deliberately. First, a test-pattern request and an engine transmit request are raised on the same strobe. The bench expects the first eye symbol, not the engine's SE0, and it expects strict alternation on the strobes that follow. Second, an illegal transmit request and err_clr are raised together. The flag must still read set afterwards, and a later clear with no set condition present must empty it.

// File: rtl/usb_line_pkg.sv
package usb_line_pkg;

    // Symbol requested on the transmit side
    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_BAD = 2'b11
    } line_sym_e;

    // Decoded receive bus state
    typedef enum logic [1:0] {
        RX_SE0  = 2'b00,
        RX_LOW  = 2'b01,
        RX_HIGH = 2'b10,
        RX_ERR  = 2'b11
    } rx_state_e;

    // Control states
    typedef enum logic [1:0] {
        ST_LISTEN     = 2'b00,
        ST_DRIVE      = 2'b01,
        ST_EYE_FIRST  = 2'b10,
        ST_EYE_SECOND = 2'b11
    } ctl_state_e;

    // Output pair values
    localparam logic [1:0] PAIR_SE0 = 2'b00;
    localparam logic [1:0] PAIR_D0  = 2'b01;
    localparam logic [1:0] PAIR_D1  = 2'b10;

endpackage

// File: rtl/uli_rx_sync.sv
module uli_rx_sync
    import usb_line_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output rx_state_e        code,
    output logic             code_err
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], din};
            end
        end
    endgenerate

    always_comb begin
        unique case (stg[LAST])
            2'b00:   code = RX_SE0;
            2'b01:   code = RX_LOW;
            2'b10:   code = RX_HIGH;
            default: code = RX_ERR;
        endcase
    end

    assign code_err = (code == RX_ERR);

endmodule

// File: rtl/uli_ctrl_fsm.sv
module uli_ctrl_fsm
    import usb_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mod_en,
    input  logic       fs_mode,
    input  logic       eye_en,
    input  logic       bit_stb,
    input  logic       tx_req,
    input  line_sym_e  tx_sym,
    output ctl_state_e state_q,
    output line_sym_e  cur_sym,
    output logic       drv_en
);

    ctl_state_e state_nxt;
    line_sym_e  sym_q;
    line_sym_e  sym_nxt;
    line_sym_e  sym_clean;

    // An illegal request is replaced by idle J
    assign sym_clean = (tx_sym == SYM_BAD) ? SYM_J : tx_sym;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LISTEN;
            sym_q   <= SYM_J;
        end else begin
            state_q <= state_nxt;
            sym_q   <= sym_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        sym_nxt   = sym_q;
        if (!mod_en) begin
            state_nxt = ST_LISTEN;
            sym_nxt   = SYM_J;
        end else if (bit_stb) begin
            unique case (state_q)
                ST_LISTEN, ST_DRIVE: begin
                    if (eye_en) begin
                        state_nxt = ST_EYE_FIRST;
                    end else if (tx_req) begin
                        state_nxt = ST_DRIVE;
                        sym_nxt   = sym_clean;
                    end else begin
                        state_nxt = ST_LISTEN;
                        sym_nxt   = SYM_J;
                    end
                end
                ST_EYE_FIRST: begin
                    state_nxt = eye_en ? ST_EYE_SECOND : ST_LISTEN;
                end
                ST_EYE_SECOND: begin
                    state_nxt = eye_en ? ST_EYE_FIRST : ST_LISTEN;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_LISTEN: begin
                cur_sym = SYM_J;
                drv_en  = 1'b0;
            end
            ST_DRIVE: begin
                cur_sym = sym_q;
                drv_en  = 1'b1;
            end
            ST_EYE_FIRST: begin
                cur_sym = fs_mode ? SYM_K : SYM_J;
                drv_en  = 1'b1;
            end
            ST_EYE_SECOND: begin
                cur_sym = fs_mode ? SYM_J : SYM_K;
                drv_en  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/uli_tx_enc.sv
module uli_tx_enc
    import usb_line_pkg::*;
(
    input  line_sym_e  sym,
    input  logic       fs_mode,
    input  logic       drv_en,
    output logic [1:0] pair,
    output logic       oe_n
);

    logic [1:0] pair_j;
    logic [1:0] pair_k;

    assign pair_j = fs_mode ? PAIR_D1 : PAIR_D0;
    assign pair_k = fs_mode ? PAIR_D0 : PAIR_D1;

    always_comb begin
        unique case (sym)
            SYM_SE0: pair = PAIR_SE0;
            SYM_K:   pair = pair_k;
            default: pair = pair_j;
        endcase
    end

    assign oe_n = ~drv_en;

endmodule

// File: rtl/uli_err_trk.sv
module uli_err_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic set_tx,
    input  logic set_rx,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (!rst_n)                flag <= 1'b0;
        else if (set_tx || set_rx) flag <= 1'b1;
        else if (clr)              flag <= 1'b0;
    end

endmodule

// File: rtl/usb_line_if.sv
module usb_line_if
    import usb_line_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mod_en,
    input  logic       fs_mode,
    input  logic       eye_en,
    input  logic       bit_stb,
    input  logic       tx_req,
    input  logic [1:0] tx_sym,
    input  logic       rx_dp,
    input  logic       rx_dm,
    input  logic       err_clr,
    output logic       tx_dp,
    output logic       tx_dm,
    output logic       oe_n,
    output logic       oe_mon,
    output logic [1:0] rx_state,
    output logic       err_flag
);

    ctl_state_e state_q;
    line_sym_e  cur_sym;
    line_sym_e  req_sym;
    logic       drv_en;
    logic [1:0] pair;
    rx_state_e  rx_code;
    logic       rx_err;
    logic       bad_req;

    assign req_sym = line_sym_e'(tx_sym);
    assign bad_req = mod_en && tx_req && (req_sym == SYM_BAD);

    uli_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mod_en  (mod_en),
        .fs_mode (fs_mode),
        .eye_en  (eye_en),
        .bit_stb (bit_stb),
        .tx_req  (tx_req),
        .tx_sym  (req_sym),
        .state_q (state_q),
        .cur_sym (cur_sym),
        .drv_en  (drv_en)
    );

    uli_tx_enc u_enc (
        .sym     (cur_sym),
        .fs_mode (fs_mode),
        .drv_en  (drv_en),
        .pair    (pair),
        .oe_n    (oe_n)
    );

    uli_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      ({rx_dp, rx_dm}),
        .code     (rx_code),
        .code_err (rx_err)
    );

    uli_err_trk u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_tx (bad_req),
        .set_rx (rx_err),
        .clr    (err_clr),
        .flag   (err_flag)
    );

    assign {tx_dp, tx_dm} = pair;
    assign oe_mon         = drv_en;
    assign rx_state       = rx_code;

endmodule

// File: rtl/uli_chk.sv
module uli_chk
    import usb_line_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       mod_en,
    input logic       fs_mode,
    input logic       eye_en,
    input logic       bit_stb,
    input logic       tx_req,
    input logic [1:0] tx_sym,
    input logic       err_clr,
    input logic       tx_dp,
    input logic       tx_dm,
    input logic       oe_n,
    input logic       oe_mon,
    input logic [1:0] rx_state,
    input logic       err_flag,
    input ctl_state_e state_q
);

    logic [1:0] pr;
    logic [1:0] j_lvl;
    logic       in_eye;
    logic       set_any;

    assign pr      = {tx_dp, tx_dm};
    assign j_lvl   = fs_mode ? 2'b10 : 2'b01;
    assign in_eye  = (state_q == ST_EYE_FIRST) || (state_q == ST_EYE_SECOND);
    assign set_any = (mod_en && tx_req && tx_sym == 2'b11) || (rx_state == 2'b11);

    p_pair_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pr != 2'b11);

    p_oe_mon_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_mon != oe_n);

    p_listen_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LISTEN) |-> oe_n);

    p_eye_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LISTEN || state_q == ST_DRIVE) && mod_en && eye_en && bit_stb)
        |=> (!oe_n && pr == 2'b01));

    p_eye_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_eye && mod_en && eye_en && bit_stb)
        |=> ((fs_mode != $past(fs_mode)) || (pr == ~$past(pr))));

    p_hold_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && !bit_stb) |=> $stable(oe_n));

    p_eye_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_eye && mod_en && !eye_en && bit_stb) |=> (oe_n && pr == j_lvl));

    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (oe_n && state_q == ST_LISTEN));

    p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_any |=> err_flag);

    p_err_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !set_any) |=> !err_flag);

    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    p_bad_to_j_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LISTEN || state_q == ST_DRIVE) && mod_en && bit_stb && !eye_en
         && tx_req && tx_sym == 2'b11)
        |=> ((fs_mode != $past(fs_mode)) || pr == j_lvl));

endmodule

bind usb_line_if uli_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_en   (mod_en),
    .fs_mode  (fs_mode),
    .eye_en   (eye_en),
    .bit_stb  (bit_stb),
    .tx_req   (tx_req),
    .tx_sym   (tx_sym),
    .err_clr  (err_clr),
    .tx_dp    (tx_dp),
    .tx_dm    (tx_dm),
    .oe_n     (oe_n),
    .oe_mon   (oe_mon),
    .rx_state (rx_state),
    .err_flag (err_flag),
    .state_q  (state_q)
);

// File: tb/sim_usb_line_if.sv
`timescale 1ns/1ps
module sim_usb_line_if;

    logic       clk = 1'b0;
    logic       rst_n, mod_en, fs_mode, eye_en, bit_stb, tx_req, rx_dp, rx_dm, err_clr;
    logic [1:0] tx_sym;
    logic       tx_dp, tx_dm, oe_n, oe_mon, err_flag;
    logic [1:0] rx_state;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    usb_line_if u0 (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .fs_mode(fs_mode), .eye_en(eye_en),
        .bit_stb(bit_stb), .tx_req(tx_req), .tx_sym(tx_sym), .rx_dp(rx_dp), .rx_dm(rx_dm),
        .err_clr(err_clr), .tx_dp(tx_dp), .tx_dm(tx_dm), .oe_n(oe_n), .oe_mon(oe_mon),
        .rx_state(rx_state), .err_flag(err_flag)
    );

    // {fs_mode, tx_sym, expected pair}
    localparam logic [4:0] TXV [8] = '{
        5'b1_00_00, 5'b1_01_10, 5'b1_10_01, 5'b1_11_10,
        5'b0_00_00, 5'b0_01_01, 5'b0_10_10, 5'b0_11_01
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) bit_stb = 1'b1;
        @(negedge clk) bit_stb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; mod_en = 1; fs_mode = 1; eye_en = 0; bit_stb = 0;
        tx_req = 0; tx_sym = 2'b00; rx_dp = 1; rx_dm = 0; err_clr = 0;
        repeat (3) @(negedge clk);
        check("R3 reset oe_n", oe_n, 1);
        check("R3 reset oe_mon", oe_mon, 0);
        check("R1 reset pair idle J", {tx_dp, tx_dm}, 2'b10);
        check("R10 reset err", err_flag, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // Vector table: R2 encodings, R11 illegal-to-J
        for (int i = 0; i < 8; i++) begin
            fs_mode = TXV[i][4];
            tx_sym  = TXV[i][3:2];
            tx_req  = 1'b1;
            strobe();
            check(TXV[i][3:2] == 2'b11 ? "R11 illegal sent as J" : "R2 tx encode",
                  {tx_dp, tx_dm}, TXV[i][1:0]);
            check("R3 oe_n low in drive", oe_n, 0);
            check("R3 oe_mon in drive", oe_mon, 1);
            if (TXV[i][3:2] == 2'b11) begin
                check("R10 illegal sets err", err_flag, 1);
                @(negedge clk) begin tx_sym = 2'b00; err_clr = 1'b1; end
                @(negedge clk) err_clr = 1'b0;
                check("R10 clear err", err_flag, 0);
            end
        end

        // R7 hold between strobes
        fs_mode = 1; tx_sym = 2'b01;
        strobe();
        check("R2 J full speed", {tx_dp, tx_dm}, 2'b10);
        tx_sym = 2'b10;
        repeat (3) @(negedge clk);
        check("R7 pair held without strobe", {tx_dp, tx_dm}, 2'b10);
        strobe();
        check("R2 K full speed", {tx_dp, tx_dm}, 2'b01);

        // R3 end of transmit
        tx_req = 0;
        strobe();
        check("R3 listen oe_n", oe_n, 1);
        check("R3 listen idle J", {tx_dp, tx_dm}, 2'b10);

        // R10 set wins over clear
        @(negedge clk) begin tx_req = 1; tx_sym = 2'b11; err_clr = 1; end
        @(negedge clk) begin tx_req = 0; tx_sym = 2'b00; err_clr = 0; end
        check("R10 set wins", err_flag, 1);
        @(negedge clk) err_clr = 1;
        @(negedge clk) err_clr = 0;
        check("R10 clear after set", err_flag, 0);

        // R4 receive decode with two-edge latency
        begin
            logic [1:0] codes [4];
            logic [1:0] prev;
            codes[0] = 2'b00; codes[1] = 2'b01; codes[2] = 2'b11; codes[3] = 2'b10;
            prev = 2'b10;
            for (int k = 0; k < 4; k++) begin
                {rx_dp, rx_dm} = codes[k];
                @(negedge clk);
                check("R4 one edge not yet", rx_state, prev);
                @(negedge clk);
                check("R4 decode", rx_state, codes[k]);
                if (codes[k] == 2'b11) begin
                    @(negedge clk);
                    check("R10 rx error sets err", err_flag, 1);
                end
                prev = codes[k];
            end
            @(negedge clk) err_clr = 1;
            @(negedge clk) err_clr = 0;
            check("R10 clear after rx error", err_flag, 0);
        end

        // R5/R6 eye at full speed, overriding an engine SE0 request
        fs_mode = 1; tx_req = 1; tx_sym = 2'b00; eye_en = 1;
        strobe();
        check("R5 eye start fs K", {tx_dp, tx_dm}, 2'b01);
        check("R5 eye oe_n", oe_n, 0);
        for (int n = 0; n < 6; n++) begin
            strobe();
            check("R6 eye alternate fs", {tx_dp, tx_dm}, (n % 2 == 0) ? 2'b10 : 2'b01);
        end
        repeat (3) @(negedge clk);
        check("R7 eye hold without strobe", {tx_dp, tx_dm}, 2'b01);
        eye_en = 0;
        strobe();
        check("R8 eye exit oe_n", oe_n, 1);
        check("R8 eye exit idle J", {tx_dp, tx_dm}, 2'b10);
        tx_req = 0;
        strobe();

        // R5/R6 eye at low speed
        fs_mode = 0; eye_en = 1;
        strobe();
        check("R5 eye start ls J", {tx_dp, tx_dm}, 2'b01);
        strobe();
        check("R6 eye ls K", {tx_dp, tx_dm}, 2'b10);
        strobe();
        check("R6 eye ls J", {tx_dp, tx_dm}, 2'b01);

        // R9 module disable
        @(negedge clk) mod_en = 0;
        @(negedge clk);
        check("R9 disable oe_n", oe_n, 1);
        check("R9 disable idle J", {tx_dp, tx_dm}, 2'b01);
        tx_req = 1; tx_sym = 2'b11;
        strobe();
        check("R9 eye ignored", oe_n, 1);
        check("R9 illegal ignored", err_flag, 0);
        tx_req = 0; tx_sym = 2'b00; eye_en = 0; mod_en = 1;
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule